// File: doc/BRIEF.md
# Multi-register vector load sequencer

This block executes one instruction that fills one to four vector registers from a single run of consecutive memory bytes. It takes a 32-bit instruction word through a valid/ready handshake and decodes from it the number of registers, the element size and the vector width. It takes the base address from a general-purpose register, or from the stack pointer when the base field holds 31. It then sends one read per element over a memory port that allows one request in flight. It builds each register from its elements and writes each destination register once. In the post-index form it also writes an updated base back.

The register count comes from a 4-bit opcode. Destination register numbers wrap modulo 32. Addresses step by the element byte count across all registers, so the loaded bytes form one contiguous block. The post-index step is either the total number of bytes transferred or the value of a second general-purpose register. Undefined encodings and a misaligned stack-pointer base end the instruction with a fault flag, with no memory traffic and no register writes.

Top module: `vls_seq`

## Requirements
- R1: Opcode bits 15:12 set the register count: 0111 gives 1, 1010 gives 2, 0110 gives 3, 0010 gives 4. Any other value ends the instruction with `flt_undef` set on the `done` cycle, with no memory request and no register or base write.
- R2: Bit 23 set selects the post-index form. Bit 23 clear with bits 20:16 all zero selects the no-offset form. Bit 23 clear with any of bits 20:16 set is undefined and is handled as in R1.
- R3: Bit 30 (Q) selects a 64-bit (0) or 128-bit (1) register. Bits 11:10 select elements of 1, 2, 4 or 8 bytes. Each register takes width/element-size elements. Every memory request carries the size field on `mem_req_size`.
- R4: Destinations are Rt (bits 4:0), then Rt+1, Rt+2 and Rt+3 modulo 32, written in that order, each exactly once and only after all of its elements have arrived.
- R5: Element k of the whole transfer is read from base + k × element bytes, counting across registers. Elements are packed little-endian, so the register holds the memory bytes in address order. Response bits above the element size are ignored.
- R6: With Q=0 the upper 64 bits of the written register are zero.
- R7: Base field Rn (bits 9:9..5) equal to 31 selects the stack pointer, any other value selects general-purpose register Rn. A stack-pointer base whose low four bits are not zero ends the instruction with `flt_align`, with no request and no writes.
- R8: The no-offset form never writes the base register or the stack pointer.
- R9: The post-index form writes base + step to register Rn, or to the stack pointer when Rn is 31. The step is register Rm (bits 20:16) when Rm is not 31. When Rm is 31 the step is 8 or 16 bytes per register for Q=0 or 1.
- R10: `in_ready` is high only while idle. `busy` is high from the cycle after acceptance until the single-cycle `done` pulse. Fault flags are high only together with `done`. After a request handshake no new request is made until the response arrives, and a request that is not yet accepted holds its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Block idle, instruction taken this cycle if valid |
| in_insn | input | 32 | Instruction word |
| base_idx | output | 5 | General register read index for the base |
| base_data | input | XLEN | Value of register `base_idx` |
| step_idx | output | 5 | General register read index for the post-index step |
| step_data | input | XLEN | Value of register `step_idx` |
| sp_data | input | XLEN | Current stack pointer |
| gpr_we | output | 1 | General register write enable |
| gpr_waddr | output | 5 | General register write index |
| gpr_wdata | output | XLEN | General register write value |
| sp_we | output | 1 | Stack pointer write enable |
| sp_wdata | output | XLEN | Stack pointer write value |
| vreg_we | output | 1 | Vector register write enable |
| vreg_waddr | output | 5 | Vector register write index |
| vreg_wdata | output | VBITS | Vector register write value |
| mem_req_valid | output | 1 | Element read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | XLEN | Element byte address |
| mem_req_size | output | 2 | Element size code (log2 bytes) |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | ELEM_BITS | Read data, element in the low bytes |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| flt_undef | output | 1 | Undefined encoding, valid with done |
| flt_align | output | 1 | Misaligned stack-pointer base, valid with done |

## Verification
The bench builds the block with XLEN=32 and the default 128-bit register and 64-bit element widths, with SP_ALIGN=16 so the alignment check variant is generated. The narrow address lets a base sit a few bytes below 2^32, so element addresses and the written-back base wrap. The bench sweeps every valid opcode, element size, width and addressing form, together with wrapping register numbers. It also runs all twelve undefined opcodes, the undefined form and a misaligned stack pointer. The memory model stalls the request side on a fixed pattern and puts junk above each element, which brings masking and held requests into reach.

// File: rtl/vls_pkg.sv
`timescale 1ns/1ps
package vls_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_DECODE, ST_REQ, ST_WAIT, ST_WRITE, ST_WB, ST_FINISH
   } vls_state_e;

   typedef struct packed {
      logic       ok;
      logic       post;
      logic       q;
      logic [1:0] esz;
      logic [2:0] nregs;
      logic [4:0] rt;
      logic [4:0] rn;
      logic [4:0] rm;
   } vls_op_t;
endpackage

// File: rtl/vls_decode.sv
`timescale 1ns/1ps
module vls_decode
   import vls_pkg::*;
(
   input  logic [31:0] insn,
   output vls_op_t     op
);
   logic unused_fields;
   assign unused_fields = ^{insn[31], insn[29:24], insn[22:21]};

   always_comb begin
      op       = '0;
      op.q     = insn[30];
      op.post  = insn[23];
      op.rm    = insn[20:16];
      op.esz   = insn[11:10];
      op.rn    = insn[9:5];
      op.rt    = insn[4:0];
      case (insn[15:12])
         4'b0111: op.nregs = 3'd1;
         4'b1010: op.nregs = 3'd2;
         4'b0110: op.nregs = 3'd3;
         4'b0010: op.nregs = 3'd4;
         default: op.nregs = 3'd0;
      endcase
      op.ok = (op.nregs != 3'd0) && (insn[23] || (insn[20:16] == 5'd0));
   end
endmodule

// File: rtl/vls_lane_merge.sv
`timescale 1ns/1ps
module vls_lane_merge #(
   parameter int VBYTES = 16,
   parameter int EBYTES = 8
) (
   input  logic [VBYTES*8-1:0]       acc,
   input  logic [EBYTES*8-1:0]       elem,
   input  logic [1:0]                esz,
   input  logic [$clog2(VBYTES):0]   boff,
   output logic [VBYTES*8-1:0]       merged
);
   localparam int OFF_W = $clog2(VBYTES) + 1;

   logic [OFF_W-1:0] elen;
   assign elen = OFF_W'(1) << esz;

   for (genvar b = 0; b < VBYTES; b++) begin : g_lane
      logic [OFF_W-1:0] rel;
      logic             hit;
      always_comb begin
         rel = OFF_W'(b) - boff;
         hit = (OFF_W'(b) >= boff) && (rel < elen);
      end
      assign merged[8*b +: 8] = hit ? 8'(elem >> {rel, 3'b000}) : acc[8*b +: 8];
   end
endmodule

// File: rtl/vls_seq.sv
`timescale 1ns/1ps
module vls_seq
   import vls_pkg::*;
#(
   parameter int XLEN      = 64,
   parameter int VBITS     = 128,
   parameter int ELEM_BITS = 64,
   parameter int SP_ALIGN  = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic [31:0]          in_insn,
   output logic [4:0]           base_idx,
   input  logic [XLEN-1:0]      base_data,
   output logic [4:0]           step_idx,
   input  logic [XLEN-1:0]      step_data,
   input  logic [XLEN-1:0]      sp_data,
   output logic                 gpr_we,
   output logic [4:0]           gpr_waddr,
   output logic [XLEN-1:0]      gpr_wdata,
   output logic                 sp_we,
   output logic [XLEN-1:0]      sp_wdata,
   output logic                 vreg_we,
   output logic [4:0]           vreg_waddr,
   output logic [VBITS-1:0]     vreg_wdata,
   output logic                 mem_req_valid,
   input  logic                 mem_req_ready,
   output logic [XLEN-1:0]      mem_req_addr,
   output logic [1:0]           mem_req_size,
   input  logic                 mem_rsp_valid,
   input  logic [ELEM_BITS-1:0] mem_rsp_data,
   output logic                 busy,
   output logic                 done,
   output logic                 flt_undef,
   output logic                 flt_align
);
   localparam int VBYTES    = VBITS / 8;
   localparam int EBYTES    = ELEM_BITS / 8;
   localparam int EI_W      = $clog2(VBYTES);
   localparam int OFF_W     = EI_W + 1;
   localparam int HALF      = VBITS / 2;
   localparam int ALIGN_LSB = (SP_ALIGN > 1) ? $clog2(SP_ALIGN) : 1;

   if (VBITS != 128)              begin : g_bad_vbits $error("VBITS must be 128"); end
   if (ELEM_BITS != 64)           begin : g_bad_ebits $error("ELEM_BITS must be 64"); end
   if (XLEN < 16)                 begin : g_bad_xlen  $error("XLEN too small"); end
   if ((SP_ALIGN & (SP_ALIGN - 1)) != 0) begin : g_bad_al $error("SP_ALIGN not a power of two"); end

   vls_state_e       state;
   logic [31:0]      insn_q;
   vls_op_t          op;
   logic [XLEN-1:0]  base_q, step_q, offs_q;
   logic [EI_W-1:0]  eidx_q;
   logic [1:0]       ridx_q;
   logic [VBITS-1:0] acc_q, merged;
   logic             fu_q, fa_q;

   vls_decode u_dec (.insn(insn_q), .op(op));

   // stack pointer alignment test, generated only when alignment is required
   logic sp_misal;
   if (SP_ALIGN > 1) begin : g_align
      assign sp_misal = |sp_data[ALIGN_LSB-1:0];
   end else begin : g_noalign
      assign sp_misal = 1'b0;
   end

   logic [XLEN-1:0]  base_sel, step_sel, imm_step, ebytes;
   logic [OFF_W-1:0] nel, boff;
   logic             last_elem, last_reg;

   always_comb begin
      base_sel  = (op.rn == 5'd31) ? sp_data : base_data;
      imm_step  = XLEN'(op.nregs) << (op.q ? 4 : 3);
      step_sel  = (op.rm == 5'd31) ? imm_step : step_data;
      ebytes    = XLEN'(1) << op.esz;
      nel       = (op.q ? OFF_W'(VBYTES) : OFF_W'(VBYTES / 2)) >> op.esz;
      boff      = OFF_W'(eidx_q) << op.esz;
      last_elem = ({1'b0, eidx_q} == nel - OFF_W'(1));
      last_reg  = ({1'b0, ridx_q} == op.nregs - 3'd1);
   end

   vls_lane_merge #(.VBYTES(VBYTES), .EBYTES(EBYTES)) u_merge (
      .acc(acc_q), .elem(mem_rsp_data), .esz(op.esz), .boff(boff), .merged(merged)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         insn_q <= '0;
         base_q <= '0;
         step_q <= '0;
         offs_q <= '0;
         eidx_q <= '0;
         ridx_q <= '0;
         acc_q  <= '0;
         fu_q   <= 1'b0;
         fa_q   <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: if (in_valid) begin
               insn_q <= in_insn;
               fu_q   <= 1'b0;
               fa_q   <= 1'b0;
               state  <= ST_DECODE;
            end
            ST_DECODE: begin
               offs_q <= '0;
               eidx_q <= '0;
               ridx_q <= '0;
               acc_q  <= '0;
               base_q <= base_sel;
               step_q <= step_sel;
               if (!op.ok) begin
                  fu_q  <= 1'b1;
                  state <= ST_FINISH;
               end else if (op.rn == 5'd31 && sp_misal) begin
                  fa_q  <= 1'b1;
                  state <= ST_FINISH;
               end else begin
                  state <= ST_REQ;
               end
            end
            ST_REQ: if (mem_req_ready) state <= ST_WAIT;
            ST_WAIT: if (mem_rsp_valid) begin
               acc_q  <= merged;
               offs_q <= offs_q + ebytes;
               if (last_elem) begin
                  eidx_q <= '0;
                  state  <= ST_WRITE;
               end else begin
                  eidx_q <= eidx_q + EI_W'(1);
                  state  <= ST_REQ;
               end
            end
            ST_WRITE: begin
               acc_q <= '0;
               if (last_reg) begin
                  state <= op.post ? ST_WB : ST_FINISH;
               end else begin
                  ridx_q <= ridx_q + 2'd1;
                  state  <= ST_REQ;
               end
            end
            ST_WB:     state <= ST_FINISH;
            default:   state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      in_ready      = (state == ST_IDLE);
      busy          = (state != ST_IDLE) && (state != ST_FINISH);
      done          = (state == ST_FINISH);
      flt_undef     = done & fu_q;
      flt_align     = done & fa_q;
      base_idx      = op.rn;
      step_idx      = op.rm;
      mem_req_valid = (state == ST_REQ);
      mem_req_addr  = base_q + offs_q;
      mem_req_size  = op.esz;
      vreg_we       = (state == ST_WRITE);
      vreg_waddr    = op.rt + 5'(ridx_q);
      vreg_wdata    = op.q ? acc_q : {{HALF{1'b0}}, acc_q[HALF-1:0]};
      gpr_we        = (state == ST_WB) && (op.rn != 5'd31);
      sp_we         = (state == ST_WB) && (op.rn == 5'd31);
      gpr_waddr     = op.rn;
      gpr_wdata     = base_q + step_q;
      sp_wdata      = base_q + step_q;
   end
endmodule

// File: rtl/vls_seq_chk.sv
`timescale 1ns/1ps
module vls_seq_chk #(
   parameter int XLEN = 64
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic            in_ready,
   input logic            busy,
   input logic            done,
   input logic            flt_undef,
   input logic            flt_align,
   input logic            mem_req_valid,
   input logic            mem_req_ready,
   input logic [XLEN-1:0] mem_req_addr,
   input logic            vreg_we,
   input logic            gpr_we,
   input logic            sp_we
);
   a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r10_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> (!busy && !done));
   a_r10_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> busy);
   a_r10_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_ready) |=> !mem_req_valid);
   a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
   a_r1_fault_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_undef || flt_align) |-> done);
   a_r7_fault_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(flt_undef && flt_align));
   a_r9_wb_alone: assert property (@(posedge clk) disable iff (!rst_n)
      (gpr_we || sp_we) |-> (!mem_req_valid && !vreg_we && busy && $onehot0({gpr_we, sp_we})));
   a_r4_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
      vreg_we |-> (busy && !mem_req_valid));
endmodule

bind vls_seq vls_seq_chk #(.XLEN(XLEN)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
   .busy(busy), .done(done), .flt_undef(flt_undef), .flt_align(flt_align),
   .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
   .mem_req_addr(mem_req_addr), .vreg_we(vreg_we), .gpr_we(gpr_we), .sp_we(sp_we)
);

// File: tb/tb_vls_seq.sv
`timescale 1ns/1ps
module tb_vls_seq;
   localparam int XL = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [31:0]   in_insn = '0;
   logic [4:0]    base_idx, step_idx, gpr_waddr, vreg_waddr;
   logic [XL-1:0] base_data, step_data, sp_data, gpr_wdata, sp_wdata, mem_req_addr;
   logic          gpr_we, sp_we, vreg_we, mem_req_valid, busy, done, flt_undef, flt_align;
   logic          mem_req_ready = 1'b0;
   logic [127:0]  vreg_wdata;
   logic [1:0]    mem_req_size;
   logic          mem_rsp_valid = 1'b0;
   logic [63:0]   mem_rsp_data = '0;

   logic [XL-1:0] gpr_m [32];
   logic [XL-1:0] sp_m;
   assign base_data = gpr_m[base_idx];
   assign step_data = gpr_m[step_idx];
   assign sp_data   = sp_m;

   always #5 clk = ~clk;

   vls_seq #(.XLEN(XL), .VBITS(128), .ELEM_BITS(64), .SP_ALIGN(16)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_insn(in_insn),
      .base_idx(base_idx), .base_data(base_data), .step_idx(step_idx), .step_data(step_data),
      .sp_data(sp_data), .gpr_we(gpr_we), .gpr_waddr(gpr_waddr), .gpr_wdata(gpr_wdata),
      .sp_we(sp_we), .sp_wdata(sp_wdata), .vreg_we(vreg_we), .vreg_waddr(vreg_waddr),
      .vreg_wdata(vreg_wdata), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_req_size(mem_req_size), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .busy(busy), .done(done), .flt_undef(flt_undef),
      .flt_align(flt_align)
   );

   int total = 0;
   int bad = 0;

   function automatic logic [7:0] mem_byte(input logic [XL-1:0] a);
      logic [XL-1:0] t;
      t = (a * 32'd13) ^ (a >> 7) ^ 32'h5A;
      return t[7:0];
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // captures from the monitor
   logic [127:0]  cap_d [8];
   logic [4:0]    cap_r [8];
   int            ncap, nreq, nsize_err, nwb;
   logic          wb_sp;
   logic [4:0]    wb_idx;
   logic [XL-1:0] wb_val;
   logic          done_seen, seen_undef, seen_align;
   logic [1:0]    exp_size;

   // monitor and memory responder, all at the falling edge
   initial begin
      logic          pend = 1'b0;
      logic [XL-1:0] paddr = '0;
      logic [1:0]    psz = '0;
      int            cyc = 0;
      forever begin
         @(negedge clk);
         cyc++;
         if (rst_n) begin
            if (vreg_we) begin
               if (ncap < 8) begin cap_d[ncap] = vreg_wdata; cap_r[ncap] = vreg_waddr; end
               ncap++;
            end
            if (gpr_we || sp_we) begin
               nwb++; wb_sp = sp_we; wb_idx = gpr_waddr; wb_val = sp_we ? sp_wdata : gpr_wdata;
            end
            if (done) begin
               done_seen = 1'b1; seen_undef = flt_undef; seen_align = flt_align;
            end
         end
         mem_rsp_valid = 1'b0;
         mem_rsp_data  = 64'hDEAD_BEEF_CAFE_F00D;
         if (pend) begin
            for (int k = 0; k < 8; k++)
               mem_rsp_data[8*k +: 8] = (k < (1 << psz)) ? mem_byte(paddr + XL'(k)) : (8'hA5 ^ 8'(k));
            mem_rsp_valid = 1'b1;
            pend = 1'b0;
         end
         mem_req_ready = (cyc % 5) != 3;
         if (rst_n && mem_req_valid && mem_req_ready) begin
            pend = 1'b1; paddr = mem_req_addr; psz = mem_req_size;
            nreq++;
            if (mem_req_size != exp_size) nsize_err++;
         end
      end
   end

   function automatic logic [31:0] enc(input bit q, input bit post, input logic [4:0] rm,
                                       input logic [3:0] opc, input logic [1:0] sz,
                                       input logic [4:0] rn, input logic [4:0] rt);
      return {1'b0, q, 6'b001100, post, 1'b1, 1'b0, rm, opc, sz, rn, rt};
   endfunction

   task automatic run_insn(input logic [31:0] w);
      bit            q, post, exp_undef, exp_align;
      logic [4:0]    rm, rn, rt;
      logic [1:0]    sz;
      int            rpt, vb, t;
      logic [XL-1:0] base, step;
      logic [127:0]  ev;
      q = w[30]; post = w[23]; rm = w[20:16]; sz = w[11:10]; rn = w[9:5]; rt = w[4:0];
      case (w[15:12])
         4'b0111: rpt = 1;
         4'b1010: rpt = 2;
         4'b0110: rpt = 3;
         4'b0010: rpt = 4;
         default: rpt = 0;
      endcase
      vb        = q ? 16 : 8;
      exp_undef = (rpt == 0) || (!post && rm != 5'd0);
      base      = (rn == 5'd31) ? sp_m : gpr_m[rn];
      exp_align = !exp_undef && rn == 5'd31 && base[3:0] != 4'd0;
      step      = (rm == 5'd31) ? XL'(rpt * vb) : gpr_m[rm];
      exp_size  = sz;
      ncap = 0; nreq = 0; nsize_err = 0; nwb = 0;
      done_seen = 1'b0; seen_undef = 1'b0; seen_align = 1'b0;
      @(negedge clk);
      in_valid = 1'b1; in_insn = w;
      @(negedge clk);
      in_valid = 1'b0;
      t = 0;
      while (!done_seen && t < 3000) begin @(posedge clk); t++; end
      chk(done_seen, "R10", "done pulse seen", 128'(done_seen), 128'd1);
      chk(seen_undef == exp_undef, exp_undef ? "R1/R2" : "R1", "undefined flag",
          128'(seen_undef), 128'(exp_undef));
      chk(seen_align == exp_align, "R7", "alignment flag", 128'(seen_align), 128'(exp_align));
      if (exp_undef || exp_align) begin
         chk(nreq == 0 && ncap == 0 && nwb == 0, "R7", "no traffic on fault",
             128'(nreq + ncap + nwb), 128'd0);
      end else begin
         chk(nreq == rpt * (vb >> sz), "R3", "request count", 128'(nreq), 128'(rpt * (vb >> sz)));
         chk(nsize_err == 0, "R3", "request size code", 128'(nsize_err), 128'd0);
         chk(ncap == rpt, "R4", "register write count", 128'(ncap), 128'(rpt));
         for (int r = 0; r < rpt && r < ncap; r++) begin
            ev = '0;
            for (int k = 0; k < vb; k++) ev[8*k +: 8] = mem_byte(base + XL'(r * vb + k));
            chk(cap_r[r] == 5'(rt + 5'(r)), "R4", "destination number",
                128'(cap_r[r]), 128'(5'(rt + 5'(r))));
            chk(cap_d[r] == ev, q ? "R5" : "R6", "register data", cap_d[r], ev);
         end
         if (post) begin
            chk(nwb == 1 && wb_sp == (rn == 5'd31) && (wb_sp || wb_idx == rn), "R9",
                "writeback target", 128'({nwb[3:0], wb_sp, wb_idx}), 128'({4'd1, rn == 5'd31, rn}));
            chk(wb_val == base + step, "R9", "writeback value", 128'(wb_val), 128'(base + step));
         end else begin
            chk(nwb == 0, "R8", "no writeback", 128'(nwb), 128'd0);
         end
      end
   endtask

   localparam logic [3:0] OPCS [4] = '{4'b0111, 4'b1010, 4'b0110, 4'b0010};

   initial begin
      for (int i = 0; i < 32; i++) gpr_m[i] = 32'h0001_0000 + 32'(i) * 32'h0000_0123;
      gpr_m[3] = 32'hFFFF_FFF8;
      gpr_m[7] = 32'h0000_0040;
      sp_m     = 32'h0000_8F40;
      exp_size = '0;
      repeat (3) @(negedge clk);
      chk(in_ready && !busy && !done && !mem_req_valid && !vreg_we && !gpr_we && !sp_we,
          "R10", "reset state", 128'({in_ready, busy, done, mem_req_valid, vreg_we}),
          128'({1'b1, 4'b0000}));
      rst_n = 1'b1;
      @(posedge clk);
      // main sweep: opcode x size x width x form (R1 R3 R4 R5 R6 R8 R9)
      for (int oi = 0; oi < 4; oi++)
         for (int sz = 0; sz < 4; sz++)
            for (int q = 0; q < 2; q++)
               for (int f = 0; f < 3; f++) begin
                  logic [4:0] rt, rn, rm;
                  rt = 5'((oi * 7 + sz * 5 + q * 3 + f * 11 + 27) % 32);
                  rn = ((sz + q + f) % 2 == 0) ? 5'd31 : 5'((oi * 3 + sz + 1) % 31);
                  rm = (f == 0) ? 5'd0 : (f == 1) ? 5'd31 : 5'((rt + 5) % 31);
                  run_insn(enc(q[0], f != 0, rm, OPCS[oi], 2'(sz), rn, rt));
               end
      // wrap of register numbers with four registers (R4)
      run_insn(enc(1'b1, 1'b1, 5'd31, 4'b0010, 2'd2, 5'd5, 5'd30));
      run_insn(enc(1'b0, 1'b0, 5'd0,  4'b0010, 2'd0, 5'd6, 5'd31));
      // address and writeback wrap near the top of the address space (R5 R9)
      run_insn(enc(1'b1, 1'b1, 5'd31, 4'b1010, 2'd1, 5'd3, 5'd2));
      run_insn(enc(1'b0, 1'b1, 5'd7,  4'b0110, 2'd3, 5'd3, 5'd9));
      // every undefined opcode (R1)
      for (int o = 0; o < 16; o++) begin
         if (o != 7 && o != 10 && o != 6 && o != 2)
            run_insn(enc(1'b1, 1'b0, 5'd0, 4'(o), 2'd0, 5'd4, 5'd1));
      end
      // undefined form: no-offset with a nonzero Rm field (R2)
      run_insn(enc(1'b0, 1'b0, 5'd5, 4'b0111, 2'd0, 5'd4, 5'd1));
      run_insn(enc(1'b1, 1'b0, 5'd31, 4'b0010, 2'd3, 5'd4, 5'd1));
      // misaligned stack pointer, then aligned again (R7)
      sp_m = 32'h0000_8F48;
      run_insn(enc(1'b1, 1'b1, 5'd31, 4'b0111, 2'd0, 5'd31, 5'd8));
      sp_m = 32'h0000_8F41;
      run_insn(enc(1'b0, 1'b0, 5'd0, 4'b1010, 2'd2, 5'd31, 5'd8));
      sp_m = 32'h0000_9000;
      run_insn(enc(1'b0, 1'b1, 5'd12, 4'b0111, 2'd1, 5'd31, 5'd8));
      repeat (4) @(posedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (180000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL R10 watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule